// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps a seconds and sub-second time-of-day count for precision time stamping. It runs on the local PTP clock. Software configures it through a small register write port: a control word, an increment, an addend, and a pair of update values (seconds, sub-seconds plus an add/subtract flag). Register selects are 0 control, 1 increment, 2 addend, 3 update seconds, 4 update sub-seconds.

Three operations are started by writing a command bit in the control word: load the time, apply an offset, and move the staged addend into the active accumulator. The hardware drops the command one cycle after taking it. In coarse mode the sub-second field grows by the increment every cycle. In fine mode a 32-bit phase accumulator adds the active addend every cycle, and the increment is applied only when that accumulator carries out. This gives a fine frequency trim. The sub-second field wraps either at 10^9 (nanoseconds) or at 2^31 (binary fraction), and carries into seconds.

The current time is presented as a registered snapshot. Seconds and sub-seconds in that snapshot always come from the same cycle.

Top module: `ptp_tod_counter`

## Requirements
- R1: In coarse mode (control bit 1 = 0) with the counter enabled, the sub-second value grows by the increment on every clock cycle in which no load or offset command executes.
- R2: In fine mode (control bit 1 = 1), a 32-bit accumulator adds the active addend every cycle. The increment is added to the sub-seconds only on cycles where the accumulator carries out, so an addend of 2^31 adds the increment once every 2 cycles and 2^30 adds it once every 4 cycles.
- R3: With control bit 2 = 1 the sub-second value wraps at 1,000,000,000. With bit 2 = 0 it wraps at 2^31. Each wrap adds one to seconds and keeps the remainder.
- R4: The 8-bit increment is taken from bits [7:0] of the increment register when the `ssinc_hi` input is low, and from bits [23:16] when it is high.
- R5: Control bit 4 (load time) replaces seconds and sub-seconds with the update registers. The update sub-seconds value is bits [30:0] of register 4.
- R6: Control bit 6 (addend load) copies the addend register into the active addend. Writing the addend register alone does not change the rate.
- R7: Control bit 5 (offset) adds the update values to the time, with sub-second wrap and carry. When bit 31 of register 4 is set, the operation subtracts instead: the seconds become time + update - 1 when the sub-second sum does not wrap, and time + update when it wraps. Software supplies 2^32 minus the seconds offset and the wrap value minus the sub-second offset.
- R8: At most one command is pending at a time. Command bits written while a command is pending are ignored. When several command bits are written together, load time wins over offset, and offset wins over addend load.
- R9: An accepted command shows on `cmd_busy` (bit 0 load time, bit 1 offset, bit 2 addend load) for exactly one cycle and then clears. The time does not advance in the cycle a load-time or offset command executes.
- R10: After reset, and whenever control bit 0 (enable) is clear, seconds and sub-seconds are zero.
- R11: `tod_sec` and `tod_ns` show the counter value one cycle late, with both fields taken from the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PTP reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 ctrl, 1 incr, 2 addend, 3 upd sec, 4 upd sub-sec) |
| reg_wdata | input | 32 | Register write data |
| ssinc_hi | input | 1 | Selects the upper byte position of the increment field |
| tod_sec | output | 32 | Snapshot of seconds |
| tod_ns | output | 31 | Snapshot of sub-seconds |
| cmd_busy | output | 3 | One-hot pending command |

## Verification
A wrong sub-second sum or wrap decision shows in `tod_ns` one cycle after the bad edge, and it grows with every later tick. The bench therefore measures differences over short windows and compares them with increment-times-carry counts. Borrow mistakes in offset subtraction show as a seconds value off by exactly one, so the counter is frozen (zero increment) during offset checks, and both the borrow and the no-borrow cases are checked in both wrap modes. Command-arbitration faults show as a second offset being applied, or as `cmd_busy` staying high longer than one cycle, within three cycles of the write.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  // register selects
  localparam logic [2:0] SEL_CTRL   = 3'd0;
  localparam logic [2:0] SEL_INCR   = 3'd1;
  localparam logic [2:0] SEL_ADDEND = 3'd2;
  localparam logic [2:0] SEL_USEC   = 3'd3;
  localparam logic [2:0] SEL_UNS    = 3'd4;
  // control word bit positions
  localparam int CB_EN    = 0;
  localparam int CB_FINE  = 1;
  localparam int CB_DEC   = 2;
  localparam int CB_LOAD  = 4;
  localparam int CB_OFFS  = 5;
  localparam int CB_ADDLD = 6;
  // one-hot command vector positions
  localparam int CMD_LOAD  = 0;
  localparam int CMD_OFFS  = 1;
  localparam int CMD_ADDLD = 2;
  localparam int CMD_N     = 3;
  localparam longint DEC_WRAP = 64'd1000000000;
endpackage

// File: rtl/ptp_tod_regs.sv
module ptp_tod_regs
  import ptp_tod_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int SEC_W      = 32,
  parameter int NS_W       = 31,
  parameter int ACC_W      = 32,
  parameter int INC_W      = 8,
  parameter int INC_HI_LSB = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        sel,
  input  logic [REG_W-1:0]  wdata,
  input  logic              inc_hi,
  output logic              en,
  output logic              fine,
  output logic              dec,
  output logic [INC_W-1:0]  inc,
  output logic [ACC_W-1:0]  addend_stage,
  output logic [SEC_W-1:0]  upd_sec,
  output logic [NS_W-1:0]   upd_ns,
  output logic              upd_sub,
  output logic [CMD_N-1:0]  cmd
);
  logic [REG_W-1:0] incr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0; fine <= 1'b0; dec <= 1'b0;
      incr_q <= '0; addend_stage <= '0;
      upd_sec <= '0; upd_ns <= '0; upd_sub <= 1'b0;
      cmd <= '0;
    end else begin
      cmd <= '0;  // a pending command executes for one cycle, then drops
      if (we) begin
        case (sel)
          SEL_CTRL: begin
            en   <= wdata[CB_EN];
            fine <= wdata[CB_FINE];
            dec  <= wdata[CB_DEC];
            if (cmd == '0) begin
              if (wdata[CB_LOAD])       cmd[CMD_LOAD]  <= 1'b1;
              else if (wdata[CB_OFFS])  cmd[CMD_OFFS]  <= 1'b1;
              else if (wdata[CB_ADDLD]) cmd[CMD_ADDLD] <= 1'b1;
            end
          end
          SEL_INCR:   incr_q       <= wdata;
          SEL_ADDEND: addend_stage <= wdata[ACC_W-1:0];
          SEL_USEC:   upd_sec      <= wdata[SEC_W-1:0];
          SEL_UNS: begin
            upd_ns  <= wdata[NS_W-1:0];
            upd_sub <= wdata[REG_W-1];
          end
          default: ;
        endcase
      end
    end
  end

  assign inc = inc_hi ? incr_q[INC_HI_LSB +: INC_W] : incr_q[INC_W-1:0];
endmodule

// File: rtl/ptp_tod_accum.sv
module ptp_tod_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             fine,
  input  logic             load,
  input  logic [ACC_W-1:0] addend_stage,
  output logic             tick
);
  logic [ACC_W-1:0] acc_q, addend_q;
  logic [ACC_W:0]   acc_sum;

  assign acc_sum = {1'b0, acc_q} + {1'b0, addend_q};
  assign tick    = fine ? acc_sum[ACC_W] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      addend_q <= '0;
    end else begin
      if (load) addend_q <= addend_stage;
      acc_q <= en ? acc_sum[ACC_W-1:0] : '0;
    end
  end
endmodule

// File: rtl/ptp_tod_core.sv
module ptp_tod_core
  import ptp_tod_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int NS_W  = 31,
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             dec,
  input  logic [INC_W-1:0] inc,
  input  logic             tick,
  input  logic             do_load,
  input  logic             do_offs,
  input  logic [SEC_W-1:0] upd_sec,
  input  logic [NS_W-1:0]  upd_ns,
  input  logic             upd_sub,
  output logic [SEC_W-1:0] sec_q,
  output logic [NS_W-1:0]  ns_q
);
  localparam logic [NS_W:0] BIN_WRAP_V = {1'b1, {NS_W{1'b0}}};
  localparam logic [NS_W:0] DEC_WRAP_V = (NS_W+1)'(DEC_WRAP);

  logic [NS_W:0]  wrap_v, ns_add, ns_sum, ns_w;
  logic           wrap;
  logic [SEC_W-1:0] sec_add, sec_n;

  always_comb begin
    wrap_v = dec ? DEC_WRAP_V : BIN_WRAP_V;
    if (do_offs)   ns_add = {1'b0, upd_ns};
    else if (tick) ns_add = (NS_W+1)'(inc);
    else           ns_add = '0;
    ns_sum  = {1'b0, ns_q} + ns_add;
    wrap    = (ns_sum >= wrap_v);
    ns_w    = wrap ? ns_sum - wrap_v : ns_sum;
    sec_add = do_offs ? upd_sec : '0;
    // subtraction: complement operands are added, a missing wrap is a borrow
    sec_n   = sec_q + sec_add + SEC_W'(wrap) - SEC_W'(do_offs && upd_sub);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sec_q <= '0;
      ns_q  <= '0;
    end else if (do_load) begin
      sec_q <= upd_sec;
      ns_q  <= upd_ns;
    end else begin
      sec_q <= sec_n;
      ns_q  <= ns_w[NS_W-1:0];
    end
  end
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int SEC_W      = 32,
  parameter int NS_W       = 31,
  parameter int ACC_W      = 32,
  parameter int INC_W      = 8,
  parameter int INC_HI_LSB = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              ssinc_hi,
  output logic [SEC_W-1:0]  tod_sec,
  output logic [NS_W-1:0]   tod_ns,
  output logic [CMD_N-1:0]  cmd_busy
);
  logic             en_q, fine_q, dec_q, upd_sub, tick;
  logic [INC_W-1:0] inc;
  logic [ACC_W-1:0] addend_stage;
  logic [SEC_W-1:0] upd_sec, sec_q;
  logic [NS_W-1:0]  upd_ns, ns_q;
  logic [CMD_N-1:0] cmd_q;

  ptp_tod_regs #(
    .REG_W(REG_W), .SEC_W(SEC_W), .NS_W(NS_W), .ACC_W(ACC_W),
    .INC_W(INC_W), .INC_HI_LSB(INC_HI_LSB)
  ) regs_i (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .inc_hi(ssinc_hi), .en(en_q), .fine(fine_q), .dec(dec_q), .inc(inc),
    .addend_stage(addend_stage), .upd_sec(upd_sec), .upd_ns(upd_ns),
    .upd_sub(upd_sub), .cmd(cmd_q)
  );

  ptp_tod_accum #(.ACC_W(ACC_W)) accum_i (
    .clk(clk), .rst(rst), .en(en_q), .fine(fine_q),
    .load(cmd_q[CMD_ADDLD]), .addend_stage(addend_stage), .tick(tick)
  );

  ptp_tod_core #(.SEC_W(SEC_W), .NS_W(NS_W), .INC_W(INC_W)) core_i (
    .clk(clk), .rst(rst), .en(en_q), .dec(dec_q), .inc(inc), .tick(tick),
    .do_load(cmd_q[CMD_LOAD]), .do_offs(cmd_q[CMD_OFFS]),
    .upd_sec(upd_sec), .upd_ns(upd_ns), .upd_sub(upd_sub),
    .sec_q(sec_q), .ns_q(ns_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tod_sec <= '0;
      tod_ns  <= '0;
    end else begin
      tod_sec <= sec_q;
      tod_ns  <= ns_q;
    end
  end

  assign cmd_busy = cmd_q;
endmodule

// File: rtl/ptp_tod_counter_chk.sv
module ptp_tod_counter_chk
  import ptp_tod_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int NS_W  = 31,
  parameter int INC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             fine,
  input logic             dec,
  input logic [CMD_N-1:0] cmd,
  input logic [INC_W-1:0] inc,
  input logic [SEC_W-1:0] sec_q,
  input logic [NS_W-1:0]  ns_q,
  input logic [SEC_W-1:0] tod_sec,
  input logic [NS_W-1:0]  tod_ns
);
  logic [NS_W:0] lim, nxt;
  assign lim = dec ? (NS_W+1)'(DEC_WRAP) : {1'b1, {NS_W{1'b0}}};
  assign nxt = {1'b0, ns_q} + (NS_W+1)'(inc);

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd)); // R8
  AST_CMD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (cmd != '0) |=> (cmd == '0)); // R9
  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    !en |=> (sec_q == '0 && ns_q == '0)); // R10
  AST_SNAPSHOT: assert property (@(posedge clk) disable iff (rst)
    en |=> (tod_sec == $past(sec_q) && tod_ns == $past(ns_q))); // R11
  AST_COARSE_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && !fine && cmd == '0 && nxt < lim)
    |=> (ns_q == $past(ns_q) + NS_W'($past(inc)) && sec_q == $past(sec_q))); // R1
endmodule

bind ptp_tod_counter ptp_tod_counter_chk #(
  .SEC_W(SEC_W), .NS_W(NS_W), .INC_W(INC_W)
) chk_i (
  .clk(clk), .rst(rst), .en(en_q), .fine(fine_q), .dec(dec_q), .cmd(cmd_q),
  .inc(inc), .sec_q(sec_q), .ns_q(ns_q), .tod_sec(tod_sec), .tod_ns(tod_ns)
);

// File: tb/ptp_tod_counter_tb_top.sv
module ptp_tod_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        ssinc_hi = 1'b0;
  logic [31:0] tod_sec;
  logic [30:0] tod_ns;
  logic [2:0]  cmd_busy;
  int errs = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] s0, s1;
  logic [30:0] n0, n1;

  localparam longint DW = 1000000000;
  localparam longint BW = 64'h8000_0000;

  always #2 clk = ~clk;

  ptp_tod_counter dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ssinc_hi(ssinc_hi),
    .tod_sec(tod_sec), .tod_ns(tod_ns), .cmd_busy(cmd_busy)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] s, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  function automatic logic [31:0] ctl(bit en, bit fine, bit dec, bit ld, bit of, bit al);
    return {25'd0, al, of, ld, 1'b0, dec, fine, en};
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // run a load/offset command on a frozen or running counter and wait
  // until the snapshot shows the result
  task automatic run_cmd(logic [31:0] c);
    wr(3'd0, c);
    idle(3);
  endtask

  task automatic set_upd(logic [31:0] sec, logic [31:0] ns);
    wr(3'd3, sec);
    wr(3'd4, ns);
  endtask

  task automatic rate(string req, int cyc, longint exp);
    idle(3);
    n0 = tod_ns;
    idle(cyc);
    n1 = tod_ns;
    check(req, longint'(n1) - longint'(n0), exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset sec", tod_sec, 0);
    check("R10 reset ns", tod_ns, 0);
    check("R9 reset busy", cmd_busy, 0);

    // disabled counter stays at zero
    wr(3'd1, 32'd5);
    set_upd(32'd9, 32'd9);
    wr(3'd0, ctl(0, 0, 1, 1, 0, 0));
    idle(5);
    check("R10 disabled ns", tod_ns, 0);
    check("R10 disabled sec", tod_sec, 0);

    // coarse rate, both increment positions
    wr(3'd0, ctl(1, 0, 1, 0, 0, 0));
    rate("R1 coarse step 5", 10, 50);
    wr(3'd1, 32'h0012_0003);
    rate("R4 low byte", 10, 30);
    ssinc_hi = 1'b1;
    rate("R4 high byte", 10, 180);
    ssinc_hi = 1'b0;

    // load time with busy timing
    wr(3'd1, 32'd10);
    set_upd(32'd7, 32'd1000);
    wr(3'd0, ctl(1, 0, 1, 1, 0, 0));
    @(negedge clk);
    check("R9 busy shows load", cmd_busy, 1);
    @(negedge clk);
    check("R9 busy cleared", cmd_busy, 0);
    @(negedge clk);
    check("R5 R11 load sec", tod_sec, 7);
    check("R5 R11 load ns", tod_ns, 1000);
    @(negedge clk);
    check("R9 R1 first tick after load", tod_ns, 1010);

    // decimal wrap
    set_upd(32'd3, 32'(DW - 6));
    run_cmd(ctl(1, 0, 1, 1, 0, 0));
    check("R3 dec pre ns", tod_ns, DW - 6);
    @(negedge clk);
    check("R3 dec wrap sec", tod_sec, 4);
    check("R3 dec wrap ns", tod_ns, 4);

    // binary wrap
    set_upd(32'd3, 32'(BW - 3));
    run_cmd(ctl(1, 0, 0, 1, 0, 0));
    check("R3 bin pre ns", tod_ns, BW - 3);
    @(negedge clk);
    check("R3 bin wrap sec", tod_sec, 4);
    check("R3 bin wrap ns", tod_ns, 7);

    // frozen counter: offsets
    wr(3'd1, 32'd0);
    set_upd(32'd10, 32'd500);
    run_cmd(ctl(1, 0, 1, 1, 0, 0));
    set_upd(32'd5, 32'd999_999_600);
    run_cmd(ctl(1, 0, 1, 0, 1, 0));
    check("R7 add sec", tod_sec, 16);
    check("R7 add ns", tod_ns, 100);
    set_upd(32'hFFFF_FFFD, 32'h8000_0000 | 32'(DW - 200));
    run_cmd(ctl(1, 0, 1, 0, 1, 0));
    check("R7 sub borrow sec", tod_sec, 12);
    check("R7 sub borrow ns", tod_ns, 999_999_900);
    set_upd(32'hFFFF_FFFE, 32'h8000_0000 | 32'(DW - 900));
    run_cmd(ctl(1, 0, 1, 0, 1, 0));
    check("R7 sub no borrow sec", tod_sec, 10);
    check("R7 sub no borrow ns", tod_ns, 999_999_000);
    set_upd(32'd20, 32'd100);
    run_cmd(ctl(1, 0, 0, 1, 0, 0));
    set_upd(32'hFFFF_FFFF, 32'h8000_0000 | 32'(BW - 300));
    run_cmd(ctl(1, 0, 0, 0, 1, 0));
    check("R7 bin sub sec", tod_sec, 18);
    check("R7 bin sub ns", tod_ns, BW - 200);

    // collision and priority
    set_upd(32'd1, 32'd1);
    wr(3'd0, ctl(1, 0, 1, 1, 0, 0));
    wr(3'd0, ctl(1, 0, 1, 0, 1, 0));
    idle(3);
    check("R8 ignored offset sec", tod_sec, 1);
    check("R8 ignored offset ns", tod_ns, 1);
    check("R8 busy idle", cmd_busy, 0);
    set_upd(32'd4, 32'd4);
    run_cmd(ctl(1, 0, 1, 1, 1, 1));
    check("R8 load wins sec", tod_sec, 4);
    check("R8 load wins ns", tod_ns, 4);

    // fine mode
    wr(3'd1, 32'd8);
    wr(3'd2, 32'h8000_0000);
    wr(3'd0, ctl(1, 1, 1, 0, 0, 0));
    rate("R6 staged addend no effect", 20, 0);
    wr(3'd0, ctl(1, 1, 1, 0, 0, 1));
    rate("R2 R6 addend half", 20, 80);
    wr(3'd2, 32'h4000_0000);
    wr(3'd0, ctl(1, 1, 1, 0, 0, 1));
    rate("R2 addend quarter", 40, 80);

    // disable again
    wr(3'd0, ctl(0, 0, 1, 0, 0, 0));
    idle(3);
    check("R10 disable sec", tod_sec, 0);
    check("R10 disable ns", tod_ns, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule